// File: doc/BRIEF.md
# Speculative Load Ordering Table

This block lets a pipeline hoist a load above stores that come before it in program order, and then find out whether doing so was safe. When the hoisted load issues, it registers its word address and destination register tag in a small associative table. Every store that follows searches the table by address. A store that hits a registered address marks that entry as broken. At the load's original program position, a check operation looks the tag up and answers with one bit: keep the speculative result, or re-execute the load.

Each of the eight entries is a small state machine with three states: `ENT_FREE`, `ENT_ARMED` and `ENT_BROKEN`. The named transitions are: `LOAD` (FREE, ARMED or BROKEN to ARMED, on an insert steered to the entry), `CLOBBER` (ARMED to BROKEN, on a store with the same word address), and `RETIRE` (ARMED or BROKEN to FREE, on a check whose tag matches). When an insert and a check reach the same entry in one cycle, `LOAD` wins. A victim selector steers each insert to a target. Its first choice is an entry already holding the same tag. Its second is the lowest-numbered free entry. Failing both, it takes the entry under a round-robin pointer and advances that pointer.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is free and `chk_done` and `chk_redo` are low.
- R2: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high, and low otherwise.
- R3: A check on a tag that was inserted, with no matching store since, gives `chk_redo` = 0.
- R4: A store whose address equals an armed entry's address in bits [31:2] breaks that entry, so its check gives `chk_redo` = 1. Bits [1:0] of both addresses are ignored.
- R5: A store whose word address differs from every entry leaves them armed, and the check gives `chk_redo` = 0.
- R6: A check on a tag that is not held in the table gives `chk_redo` = 1.
- R7: A check frees its entry whatever the result, so a second check of the same tag gives `chk_redo` = 1.
- R8: An insert whose tag is already held overwrites that entry with the new address and re-arms it. A violation on the old address is dropped, and a later store to the old address has no effect.
- R9: The table holds 8 entries. With all 8 in use, an insert of a new tag evicts entries in round-robin order, starting at entry 0 after reset. Free entries fill lowest index first. A check on an evicted tag gives `chk_redo` = 1.
- R10: A store and an insert to the same word address in the same cycle leave the new entry armed, because the store counts as the older operation.
- R11: A store in the same cycle as a check, to the checked entry's word address, makes that check give `chk_redo` = 1.
- R12: `chk_redo` is low in every cycle in which `chk_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | A hoisted load registers its address this cycle |
| ins_addr | input | 32 | Byte address of the hoisted load |
| ins_tag | input | 5 | Destination register tag of the hoisted load |
| st_valid | input | 1 | A store searches the table this cycle |
| st_addr | input | 32 | Byte address of the store |
| chk_valid | input | 1 | Check operation for a tag this cycle |
| chk_tag | input | 5 | Tag being checked |
| chk_done | output | 1 | Check result valid (one cycle after `chk_valid`) |
| chk_redo | output | 1 | Load must be re-executed (qualified by `chk_done`) |

## Verification
Single loads are checked three ways: with no store between insert and check, with a store to the same word at a different byte offset, and with a store to the neighbouring word. Together these show that the compare is done on the word and that an unrelated store leaves the entry armed. Tag reuse, repeated checks and never-inserted tags exercise the lookup and the retire step. The table is filled past capacity twice, which shows the round-robin victim order apart from the free-first order. Same-cycle store/insert and store/check pairs settle which operation is taken as the older one.

// File: rtl/slt_pkg.sv
package slt_pkg;
    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,
        ENT_ARMED  = 2'd1,
        ENT_BROKEN = 2'd2
    } ent_state_e;
endpackage

// File: rtl/slt_entry.sv
module slt_entry
    import slt_pkg::*;
#(
    parameter int WORD_W = 30,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_sel,
    input  logic [WORD_W-1:0] ins_word,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic              st_valid,
    input  logic [WORD_W-1:0] st_word,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              busy,
    output logic              ins_tag_hit,
    output logic              chk_hit,
    output logic              chk_ok
);
    ent_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [TAG_W-1:0]  tag_q;
    logic              st_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // payload captured on LOAD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            tag_q  <= '0;
        end else if (ins_sel) begin
            word_q <= ins_word;
            tag_q  <= ins_tag;
        end
    end

    // next state and outputs
    always_comb begin
        busy        = (state_q != ENT_FREE);
        st_hit      = st_valid && (state_q == ENT_ARMED) && (word_q == st_word);
        ins_tag_hit = busy && (tag_q == ins_tag);
        chk_hit     = chk_valid && busy && (tag_q == chk_tag);
        chk_ok      = (state_q == ENT_ARMED) && !st_hit;
        state_d     = state_q;
        unique case (state_q)
            ENT_FREE: begin
                if (ins_sel) state_d = ENT_ARMED;            // LOAD
            end
            ENT_ARMED: begin
                if (ins_sel)      state_d = ENT_ARMED;       // LOAD (reuse)
                else if (chk_hit) state_d = ENT_FREE;        // RETIRE
                else if (st_hit)  state_d = ENT_BROKEN;      // CLOBBER
            end
            ENT_BROKEN: begin
                if (ins_sel)      state_d = ENT_ARMED;       // LOAD
                else if (chk_hit) state_d = ENT_FREE;        // RETIRE
            end
            default: state_d = ENT_FREE;
        endcase
    end
endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [ENTRIES-1:0] busy,
    input  logic [ENTRIES-1:0] tag_hit,
    output logic [ENTRIES-1:0] sel
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] free_pick;
    logic               any_free;
    logic               replace;

    always_comb begin
        free_pick = '0;
        any_free  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !any_free) begin
                free_pick[i] = 1'b1;
                any_free     = 1'b1;
            end
        end
    end

    always_comb begin
        sel     = '0;
        replace = 1'b0;
        if (ins_valid) begin
            if (|tag_hit) begin
                sel = tag_hit;
            end else if (any_free) begin
                sel = free_pick;
            end else begin
                sel[rr_q] = 1'b1;
                replace   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (replace) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_done,
    output logic              chk_redo
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]  ins_word, st_word;
    logic [ENTRIES-1:0] busy, tag_hit, sel, chk_hit, chk_ok;
    logic               redo_d, done_q, redo_q;
    logic               unused_low_bits;

    assign ins_word        = ins_addr[ADDR_W-1:2];
    assign st_word         = st_addr[ADDR_W-1:2];
    assign unused_low_bits = ^{ins_addr[1:0], st_addr[1:0]};

    slt_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .busy      (busy),
        .tag_hit   (tag_hit),
        .sel       (sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        slt_entry #(.WORD_W(WORD_W), .TAG_W(TAG_W)) ent_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .ins_sel     (sel[g]),
            .ins_word    (ins_word),
            .ins_tag     (ins_tag),
            .st_valid    (st_valid),
            .st_word     (st_word),
            .chk_valid   (chk_valid),
            .chk_tag     (chk_tag),
            .busy        (busy[g]),
            .ins_tag_hit (tag_hit[g]),
            .chk_hit     (chk_hit[g]),
            .chk_ok      (chk_ok[g])
        );
    end

    assign redo_d = ~|(chk_hit & chk_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            redo_q <= 1'b0;
        end else begin
            done_q <= chk_valid;
            redo_q <= chk_valid && redo_d;
        end
    end

    assign chk_done = done_q;
    assign chk_redo = redo_q;
endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             chk_valid,
    input logic [TAG_W-1:0] chk_tag,
    input logic             chk_done,
    input logic             chk_redo
);
    AST_DONE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done);  // R2

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done);  // R2

    AST_REDO_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> !chk_redo);  // R12

    AST_RECHECK_REDO: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && $past(chk_valid) && chk_tag == $past(chk_tag) && !$past(ins_valid))
        |=> chk_redo);  // R7
endmodule

bind spec_load_table spec_load_table_chk #(.TAG_W(TAG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .chk_valid (chk_valid),
    .chk_tag   (chk_tag),
    .chk_done  (chk_done),
    .chk_redo  (chk_redo)
);

// File: tb/spec_load_table_tb.sv
`timescale 1ns/1ps
module spec_load_table_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
    logic [31:0] ins_addr = '0, st_addr = '0;
    logic [4:0]  ins_tag = '0, chk_tag = '0;
    logic        chk_done, chk_redo;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;
    bit    ended = 0;

    always #2.5 clk = ~clk;

    spec_load_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_tag(ins_tag),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_done(chk_done), .chk_redo(chk_redo)
    );

    // behavioural reference: 0 free, 1 armed, 2 broken
    int          m_state [8];
    logic [4:0]  m_tag   [8];
    logic [29:0] m_word  [8];
    int          m_rr;
    logic        exp_done = 1'b0, exp_redo = 1'b0;

    always @(posedge clk) begin
        int hit, tgt;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_state[i] = 0;
            m_rr = 0; exp_done = 0; exp_redo = 0;
        end else begin
            hit = -1;
            for (int i = 0; i < 8; i++)
                if (m_state[i] != 0 && m_tag[i] == chk_tag) hit = i;
            exp_done = chk_valid;
            exp_redo = chk_valid && !(hit >= 0 && m_state[hit] == 1 &&
                       !(st_valid && m_word[hit] == st_addr[31:2]));
            tgt = -1;
            if (ins_valid) begin
                for (int i = 0; i < 8; i++)
                    if (m_state[i] != 0 && m_tag[i] == ins_tag) tgt = i;
                if (tgt < 0)
                    for (int i = 7; i >= 0; i--) if (m_state[i] == 0) tgt = i;
                if (tgt < 0) begin tgt = m_rr; m_rr = (m_rr + 1) % 8; end
            end
            if (st_valid)
                for (int i = 0; i < 8; i++)
                    if (m_state[i] == 1 && m_word[i] == st_addr[31:2]) m_state[i] = 2;
            if (chk_valid && hit >= 0) m_state[hit] = 0;
            if (tgt >= 0) begin
                m_state[tgt] = 1; m_tag[tgt] = ins_tag; m_word[tgt] = ins_addr[31:2];
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !ended) begin
            checks++;
            if (chk_done !== exp_done || chk_redo !== exp_redo) begin
                errors++;
                $display("FAIL %s: done/redo actual %b/%b expected %b/%b at %0t",
                         cur_req, chk_done, chk_redo, exp_done, exp_redo, $time);
            end
        end
    end

    task automatic cyc(input bit iv, input logic [4:0] it, input logic [31:0] ia,
                       input bit sv, input logic [31:0] sa,
                       input bit cv, input logic [4:0] ct);
        @(negedge clk);
        ins_valid = iv; ins_tag = it; ins_addr = ia;
        st_valid = sv; st_addr = sa;
        chk_valid = cv; chk_tag = ct;
    endtask
    task automatic ins(input logic [4:0] t, input logic [31:0] a); cyc(1, t, a, 0, 0, 0, 0); endtask
    task automatic st(input logic [31:0] a); cyc(0, 0, 0, 1, a, 0, 0); endtask
    task automatic chk(input logic [4:0] t); cyc(0, 0, 0, 0, 0, 1, t); endtask
    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (chk_done !== 1'b0 || chk_redo !== 1'b0) begin
            errors++;
            $display("FAIL R1: done/redo actual %b/%b expected 0/0", chk_done, chk_redo);
        end
        rst_n = 1'b1;
        @(posedge clk);
        cmp_on = 1;
        idle(); idle();

        cur_req = "R6";  chk(5'd3); idle();
        cur_req = "R3";  ins(5'd1, 32'h100); idle(); chk(5'd1); idle();
        cur_req = "R4";  ins(5'd2, 32'h200); st(32'h203); chk(5'd2); idle();
        cur_req = "R5";  ins(5'd3, 32'h300); st(32'h304); st(32'h2FC); chk(5'd3); idle();
        cur_req = "R7";  ins(5'd4, 32'h400); chk(5'd4); chk(5'd4); idle();
        cur_req = "R8";  ins(5'd5, 32'h500); st(32'h500); ins(5'd5, 32'h600); chk(5'd5); idle();
        ins(5'd6, 32'h700); ins(5'd6, 32'h800); st(32'h700); chk(5'd6); idle();
        cur_req = "R9";
        for (int k = 0; k < 8; k++) ins(5'(10 + k), 32'h1000 + 32'(k * 4));
        ins(5'd20, 32'h2000); chk(5'd10); chk(5'd11);
        ins(5'd21, 32'h2004); ins(5'd22, 32'h2008); chk(5'd21); chk(5'd12);
        for (int k = 13; k < 18; k++) chk(5'(k));
        chk(5'd20); chk(5'd22); idle();
        cur_req = "R10"; cyc(1, 5'd7, 32'h900, 1, 32'h901, 0, 0); chk(5'd7); idle();
        cur_req = "R11"; ins(5'd8, 32'hA00); cyc(0, 0, 0, 1, 32'hA02, 1, 5'd8); idle();
        ins(5'd9, 32'hB00); cyc(0, 0, 0, 1, 32'hC00, 1, 5'd9); idle();
        cur_req = "R12"; idle(); idle(); idle();
        finish_run();
    end
endmodule